// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer behind a 10-bit successive-approximation analog-to-digital converter in a microcontroller. One software-visible start flag does three jobs. Writing 1 to it while idle launches a conversion. It reads as 1 while the conversion runs. Writing 0 to it while busy aborts the conversion. An external trigger pin can also start a conversion. The pin is synchronized, and the active edge is selectable. Trigger starts are gated by two enable bits, and both must be 1.

While a conversion runs, the block drives a trial code to the external DAC. It reads back one comparator bit each clock and resolves one result bit per clock, starting at the MSB. On completion it stores the result, drops the start flag and sets a sticky end-of-conversion request flag. The request flag produces an interrupt when the interrupt is enabled.

The configuration bits are level inputs held by the surrounding register file. Software writes to the start flag and to the request flag arrive as strobe/data pairs. There is no streaming data path, so every pin is a plain control or status signal and carries no valid/ready handshake.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, start_flag, req_flag, irq, dac_code and result are all 0.
- R2: A write of 1 to the start flag (start_we=1, start_wd=1) while idle makes start_flag read 1 from the next clock. Trial code 10'h200 (MSB set) appears on dac_code in that same cycle.
- R3: Each clock during a conversion resolves one bit, MSB first. The bit under trial is kept when cmp_hi=1 (input at or above dac_code) and cleared when cmp_hi=0, and the next lower bit is then set on trial. With an ideal comparator the result equals the input code.
- R4: start_flag clears by itself exactly 10 clocks after the start was accepted. result takes the new value on that same clock, and dac_code returns to 0.
- R5: Completion sets req_flag. req_flag stays 1 until a write of 0 to it (req_we=1, req_wd=0). A write of 1 to it has no effect.
- R6: irq is 1 exactly when req_flag=1 and irq_en=1.
- R7: A write of 0 to the start flag during a conversion stops it on the next clock: start_flag=0 and dac_code=0. result keeps its previous value, and req_flag is not set.
- R8: A trigger edge starts a conversion only when trg_pin_en=1 and trg_en=1. If either enable is 0, the edge is ignored.
- R9: trg_pin passes through a two-flop synchronizer. With trg_rise_sel=0 a falling edge starts a conversion; with trg_rise_sel=1 a rising edge does. start_flag reads 1 three clocks after the pin changes, and the edge of the other direction does nothing.
- R10: A software start or trigger edge that arrives during a conversion is ignored. The conversion ends on schedule with an unchanged result, and no new conversion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_we | input | 1 | Write strobe for the start flag |
| start_wd | input | 1 | Data written to the start flag |
| req_we | input | 1 | Write strobe for the request flag |
| req_wd | input | 1 | Data written to the request flag (0 clears) |
| irq_en | input | 1 | Interrupt enable |
| trg_pin_en | input | 1 | Trigger pin function enable |
| trg_en | input | 1 | Trigger start enable |
| trg_rise_sel | input | 1 | Trigger edge select: 0 falling, 1 rising |
| trg_pin | input | 1 | Asynchronous external trigger pin |
| cmp_hi | input | 1 | Comparator: 1 when input >= dac_code |
| start_flag | output | 1 | Start/busy flag |
| dac_code | output | 10 | Trial code driven to the DAC |
| result | output | 10 | Last completed conversion result |
| req_flag | output | 1 | Sticky end-of-conversion request |
| irq | output | 1 | Interrupt output |

## Verification
The hardest case to reach is a trigger edge that lands during a running conversion. The pin edge takes three clocks to reach the start logic, so it must be launched a few cycles after a software start for the edge to fall inside the 10-clock window. The stimulus raises the pin two clocks into a conversion and also rewrites the start flag. It then checks that the flag falls on the tenth clock and stays low afterwards. An abort is placed mid-conversion, after a known result has been stored, so that preservation of the result can be seen at the ports.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int RES_W_DEF  = 10;
  localparam int SYNC_N_DEF = 2;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/sar_trig_detect.sv
module sar_trig_detect #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  input  logic gate,
  output logic hit
);
  import sar_pkg::*;

  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;
  logic              level;
  edge_sel_e         sel;

  generate
    for (genvar g = 0; g < SYNC_N; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= pin;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign level = sync_q[SYNC_N-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  always_comb begin
    sel = edge_sel_e'(rise_sel);
    unique case (sel)
      EDGE_RISE: hit = gate & level & ~prev_q;
      default:   hit = gate & ~level & prev_q;
    endcase
  end
endmodule

// File: rtl/sar_step_engine.sv
module sar_step_engine #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             cmp_hi,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] result
);
  localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_W - 1);
  localparam logic [RES_W-1:0] MSB_TRIAL = {1'b1, {(RES_W-1){1'b0}}};

  logic [IDX_W-1:0] idx_q;
  logic [RES_W-1:0] code_q;
  logic [RES_W-1:0] res_q;
  logic             busy_q;
  logic [RES_W-1:0] code_nx;
  logic             last;

  assign last = (idx_q == '0);

  always_comb begin
    code_nx        = code_q;
    code_nx[idx_q] = cmp_hi;
    if (!last) code_nx[idx_q - 1'b1] = 1'b1;
  end

  assign done = busy_q & last & ~abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      code_q <= '0;
      res_q  <= '0;
    end else if (abort) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      code_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      idx_q  <= TOP_IDX;
      code_q <= MSB_TRIAL;
    end else if (busy_q) begin
      if (last) begin
        busy_q <= 1'b0;
        res_q  <= code_nx;
        code_q <= '0;
      end else begin
        idx_q  <= idx_q - 1'b1;
        code_q <= code_nx;
      end
    end
  end

  assign busy   = busy_q;
  assign trial  = code_q;
  assign result = res_q;
endmodule

// File: rtl/sar_eoc_flag.sv
module sar_eoc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic wr_en,
  input  logic wr_data,
  input  logic int_en,
  output logic flag,
  output logic int_out
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                flag_q <= 1'b0;
    else if (set)              flag_q <= 1'b1;
    else if (wr_en && !wr_data) flag_q <= 1'b0;
  end

  assign flag    = flag_q;
  assign int_out = flag_q & int_en;
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int RES_W  = sar_pkg::RES_W_DEF,
  parameter int SYNC_N = sar_pkg::SYNC_N_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_we,
  input  logic             start_wd,
  input  logic             req_we,
  input  logic             req_wd,
  input  logic             irq_en,
  input  logic             trg_pin_en,
  input  logic             trg_en,
  input  logic             trg_rise_sel,
  input  logic             trg_pin,
  input  logic             cmp_hi,
  output logic             start_flag,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] result,
  output logic             req_flag,
  output logic             irq
);
  logic trig_hit;
  logic busy;
  logic done;
  logic go;
  logic stop;

  sar_trig_detect #(.SYNC_N(SYNC_N)) u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (trg_pin),
    .rise_sel (trg_rise_sel),
    .gate     (trg_pin_en & trg_en),
    .hit      (trig_hit)
  );

  assign stop = busy & start_we & ~start_wd;
  assign go   = ~busy & ((start_we & start_wd) | trig_hit);

  sar_step_engine #(.RES_W(RES_W)) u_eng (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (go),
    .abort  (stop),
    .cmp_hi (cmp_hi),
    .busy   (busy),
    .done   (done),
    .trial  (dac_code),
    .result (result)
  );

  sar_eoc_flag u_eoc (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (done),
    .wr_en   (req_we),
    .wr_data (req_wd),
    .int_en  (irq_en),
    .flag    (req_flag),
    .int_out (irq)
  );

  assign start_flag = busy;
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_we,
  input logic             start_wd,
  input logic             req_we,
  input logic             req_wd,
  input logic             irq_en,
  input logic             start_flag,
  input logic [RES_W-1:0] dac_code,
  input logic [RES_W-1:0] result,
  input logic             req_flag,
  input logic             irq
);
  localparam int CW = $clog2(RES_W + 2) + 1;
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_cnt <= '0;
    else if (start_flag) run_cnt <= run_cnt + 1'b1;
    else                 run_cnt <= '0;
  end

  // R4
  busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= CW'(RES_W));

  // R5
  req_set_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_flag) |-> $fell(start_flag));

  // R5
  req_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_flag) |-> $past(req_we && !req_wd));

  // R6
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  // R7
  abort_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_flag && start_we && !start_wd) |=> (!start_flag && dac_code == '0));

  // R7
  result_only_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> $fell(start_flag));

  // R2
  idle_code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_flag |-> dac_code == '0);
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.RES_W(RES_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_we   (start_we),
  .start_wd   (start_wd),
  .req_we     (req_we),
  .req_wd     (req_wd),
  .irq_en     (irq_en),
  .start_flag (start_flag),
  .dac_code   (dac_code),
  .result     (result),
  .req_flag   (req_flag),
  .irq        (irq)
);

// File: tb/tb_sar_adc_ctrl.sv
module tb_sar_adc_ctrl;
  localparam int W = 10;
  localparam int NV = 8;
  localparam logic [W-1:0] VIN  [NV] = '{10'd0, 10'd1023, 10'd512, 10'd511,
                                         10'd341, 10'd682, 10'd1, 10'd1022};
  localparam logic [W-1:0] VEXP [NV] = '{10'd0, 10'd1023, 10'd512, 10'd511,
                                         10'd341, 10'd682, 10'd1, 10'd1022};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_we = 0, start_wd = 0, req_we = 0, req_wd = 0;
  logic irq_en = 0, trg_pin_en = 0, trg_en = 0, trg_rise_sel = 0, trg_pin = 0;
  logic cmp_hi;
  logic start_flag, req_flag, irq;
  logic [W-1:0] dac_code, result;
  logic [W-1:0] vin = '0;
  int n_chk = 0;
  int n_bad = 0;
  logic done_flag = 0;

  always #5 clk = ~clk;

  assign cmp_hi = (vin >= dac_code);

  sar_adc_ctrl dut (
    .clk(clk), .rst_n(rst_n), .start_we(start_we), .start_wd(start_wd),
    .req_we(req_we), .req_wd(req_wd), .irq_en(irq_en), .trg_pin_en(trg_pin_en),
    .trg_en(trg_en), .trg_rise_sel(trg_rise_sel), .trg_pin(trg_pin),
    .cmp_hi(cmp_hi), .start_flag(start_flag), .dac_code(dac_code),
    .result(result), .req_flag(req_flag), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sw_start(input logic v);
    start_we = 1; start_wd = v;
    cyc(1);
    start_we = 0; start_wd = 0;
  endtask

  task automatic req_write(input logic v);
    req_we = 1; req_wd = v;
    cyc(1);
    req_we = 0; req_wd = 0;
  endtask

  task automatic run_conv(input logic [W-1:0] v, input logic [W-1:0] e);
    vin = v;
    sw_start(1'b1);
    chk("R2 start_flag after write", start_flag, 1);
    chk("R2 msb trial", dac_code, 10'h200);
    cyc(9);
    chk("R4 still busy at clock 9", start_flag, 1);
    cyc(1);
    chk("R4 flag clears at clock 10", start_flag, 0);
    chk("R3 result", result, e);
    chk("R4 dac idle", dac_code, 0);
    chk("R5 req set", req_flag, 1);
    chk("R6 irq enabled", irq, 1);
    req_write(1'b0);
    chk("R5 req cleared", req_flag, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_up();
  end

  initial begin
    cyc(2);
    chk("R1 start_flag", start_flag, 0);
    chk("R1 req_flag", req_flag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 result", result, 0);
    chk("R1 dac_code", dac_code, 0);
    rst_n = 1;
    cyc(1);

    irq_en = 1;
    for (int i = 0; i < NV; i++) run_conv(VIN[i], VEXP[i]);

    // R5 / R6: sticky flag, write-1 ignored, mask
    vin = 10'd300;
    sw_start(1'b1);
    cyc(10);
    req_write(1'b1);
    chk("R5 write 1 no effect", req_flag, 1);
    irq_en = 0;
    cyc(1);
    chk("R6 irq masked", irq, 0);
    cyc(5);
    chk("R5 req sticky", req_flag, 1);
    irq_en = 1;
    cyc(1);
    chk("R6 irq unmasked", irq, 1);
    req_write(1'b0);
    chk("R6 irq drops with req", irq, 0);

    // R7: abort mid conversion keeps result 300
    vin = 10'd700;
    sw_start(1'b1);
    cyc(4);
    sw_start(1'b0);
    chk("R7 aborted flag", start_flag, 0);
    chk("R7 aborted dac", dac_code, 0);
    chk("R7 result kept", result, 300);
    cyc(12);
    chk("R7 no req", req_flag, 0);
    chk("R7 result still kept", result, 300);

    // R9: falling edge selected
    trg_pin_en = 1; trg_en = 1; trg_rise_sel = 0;
    vin = 10'd77;
    trg_pin = 1;
    cyc(4);
    chk("R9 rise ignored with fall select", start_flag, 0);
    trg_pin = 0;
    cyc(3);
    chk("R9 falling edge starts", start_flag, 1);
    cyc(10);
    chk("R9 trig result", result, 77);
    req_write(1'b0);
    // R9: rising edge selected
    trg_rise_sel = 1;
    vin = 10'd900;
    cyc(1);
    trg_pin = 1;
    cyc(3);
    chk("R9 rising edge starts", start_flag, 1);
    cyc(10);
    chk("R9 rise result", result, 900);
    req_write(1'b0);
    trg_pin = 0;
    cyc(4);
    chk("R9 fall ignored with rise select", start_flag, 0);

    // R8: gating
    trg_en = 0;
    trg_pin = 1;
    cyc(4);
    chk("R8 trg_en off", start_flag, 0);
    trg_pin = 0;
    trg_en = 1; trg_pin_en = 0;
    cyc(2);
    trg_pin = 1;
    cyc(4);
    chk("R8 pin_en off", start_flag, 0);
    trg_pin = 0;
    trg_pin_en = 1;
    cyc(4);

    // R10: restart attempts during conversion
    vin = 10'd450;
    sw_start(1'b1);
    trg_pin = 1;
    cyc(1);
    sw_start(1'b1);
    cyc(7);
    chk("R10 still busy clock 9", start_flag, 1);
    cyc(1);
    chk("R10 ends on schedule", start_flag, 0);
    chk("R10 result unchanged", result, 450);
    cyc(3);
    chk("R10 no restart", start_flag, 0);
    trg_pin_en = 0; trg_en = 0;

    cyc(2);
    finish_up();
  end
endmodule